// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Bridge

This peripheral contains two 32-bit down-counters behind one small register bus. Each counter has a value register that software can write and read, and a reload register. A control word holds a run bit and a repeat bit for each counter. In repeat mode the counter loads its reload value when it expires and keeps going, so it suits a periodic tick. A counter loaded with all ones and set to repeat wraps without stopping, and software gets a rising timestamp by inverting the value it reads. With repeat mode off, software writes a delay into the value register and sets the run bit. The counter then fires once, stops itself and stays at zero.

Each expiry sets a latched cause bit in an interrupt bridge. A mask register selects which cause bits drive the single interrupt line. A write to the cause register clears only the bits written as zero, so the service routine for one counter does not touch the other counter's pending event. The bus is plain and has no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational and valid in the same cycle as `bus_sel` with `bus_wr` low. There is no streaming data path, so no valid/ready pair is needed.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every register reads zero, both counters are stopped, all causes are clear, all mask bits are clear, and `irq` is low.
- R2: The register map uses these byte offsets: control 0x000, counter 0 reload 0x010, counter 0 value 0x014, counter 1 reload 0x018, counter 1 value 0x01C, cause 0x110, mask 0x114. A written reload value reads back unchanged.
- R3: While its run bit is set, a counter's value drops by one on each clock edge while it is above zero. While its run bit is clear, the value holds.
- R4: When a running counter with its repeat bit set is at zero, the next edge loads the reload value. The period is therefore reload+1 clocks.
- R5: Control bit 0 is the run bit and bit 1 the repeat bit of counter 0; bits 2 and 3 do the same for counter 1. A running counter with repeat clear that is at zero clears its own run bit at the next edge and stays at zero. A control write in that same cycle takes precedence.
- R6: A bus write to a value register takes effect at that edge, and it overrides the decrement or reload that would otherwise happen.
- R7: An expiry (running and at zero) sets a cause bit whether or not that bit is masked. Bit 1 belongs to counter 0 and bit 2 to counter 1.
- R8: A write to the cause register clears each cause bit written as 0 and keeps each bit written as 1. An expiry in the same cycle still sets its bit.
- R9: `irq` is high exactly when some cause bit and its mask bit (same positions as R7) are both set.
- R10: Reading an unmapped offset returns zero, and writing one changes no register. Control bits above 3, and cause or mask bits other than 1 and 2, read as zero.
- R11: A repeating counter whose reload is all ones goes from 0 to 0xFFFFFFFF and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counters step on every rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational, zero when no read is active |
| irq | output | 1 | Interrupt request: OR of the masked cause bits |

## Verification
The bench builds the block with its default parameters: 32-bit counters and data, and a 12-bit address. At this width every offset is decoded, including the bridge registers at 0x110 and 0x114 and unmapped offsets both below and above them. Because the value register is writable, a full 32-bit wrap is reached within a few clocks: load a small value with the reload set to all ones. Random writes of small delays and reloads make both counters expire many times, and often in the same cycle as a cause or control write. This brings the set-beats-clear and control-beats-self-stop orderings within reach.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  localparam int unsigned NUM_TMR = 2;

  // byte offsets of the register map
  localparam int unsigned OFS_CTRL  = 'h000;
  localparam int unsigned OFS_REL0  = 'h010;
  localparam int unsigned OFS_VAL0  = 'h014;
  localparam int unsigned OFS_REL1  = 'h018;
  localparam int unsigned OFS_VAL1  = 'h01C;
  localparam int unsigned OFS_CAUSE = 'h110;
  localparam int unsigned OFS_MASK  = 'h114;

  // cause / mask bit of timer t is CAUSE_LSB + t
  localparam int unsigned CAUSE_LSB = 1;
  // control bits per timer: run at 2t, repeat at 2t+1
  localparam int unsigned CTL_BITS  = 2;

  typedef struct packed {
    logic                 ctrl;
    logic [NUM_TMR-1:0]   rel;
    logic [NUM_TMR-1:0]   val;
    logic                 cause;
    logic                 mask;
  } dtt_hit_t;

endpackage

// File: rtl/dtt_decode.sv
module dtt_decode
  import dtt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dtt_hit_t          hit,
  output logic              any_hit
);

  always_comb begin
    hit        = '0;
    hit.ctrl   = (addr == ADDR_W'(OFS_CTRL));
    hit.rel[0] = (addr == ADDR_W'(OFS_REL0));
    hit.val[0] = (addr == ADDR_W'(OFS_VAL0));
    hit.rel[1] = (addr == ADDR_W'(OFS_REL1));
    hit.val[1] = (addr == ADDR_W'(OFS_VAL1));
    hit.cause  = (addr == ADDR_W'(OFS_CAUSE));
    hit.mask   = (addr == ADDR_W'(OFS_MASK));
  end

  assign any_hit = |hit;

  // R2: at most one register selected for any offset
  always_comb begin
    assert_decode_onehot_R2: assert ($onehot0(hit))
      else $error("decode selects more than one register");
  end

endmodule

// File: rtl/dtt_counter.sv
module dtt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run_in,
  input  logic             ctl_rep_in,
  input  logic             val_we,
  input  logic [CNT_W-1:0] val_in,
  input  logic             rel_we,
  input  logic [CNT_W-1:0] rel_in,
  output logic             run,
  output logic             rep,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  assign expire = run && (count == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      rep    <= 1'b0;
      count  <= ZERO;
      reload <= ZERO;
    end else begin
      if (rel_we) reload <= rel_in;

      if (ctl_we) begin
        run <= ctl_run_in;
        rep <= ctl_rep_in;
      end else if (expire && !rep) begin
        run <= 1'b0;
      end

      if (val_we) begin
        count <= val_in;
      end else if (run) begin
        if (count == ZERO) count <= rep ? reload : ZERO;
        else               count <= count - ONE;
      end
    end
  end

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !val_we) |=> $stable(count))
    else $error("stopped counter changed");

  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count != ZERO && !val_we) |=> count == $past(count) - ONE)
    else $error("running counter did not step down by one");

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rep && count == ZERO && !val_we) |=> count == $past(reload))
    else $error("repeating counter did not reload");

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rep && count == ZERO && !val_we && !ctl_we) |=> (!run && count == ZERO))
    else $error("one-shot counter did not stop at zero");

  assert_value_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |=> count == $past(val_in))
    else $error("value write lost");

  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rep && count == ZERO && reload == '1 && !val_we) |=> count == '1)
    else $error("all-ones reload did not wrap");

endmodule

// File: rtl/dtt_irq_bridge.sv
module dtt_irq_bridge #(
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_BIT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cause_we,
  input  logic               mask_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] set_in,
  output logic [NUM_SRC-1:0] cause,
  output logic [NUM_SRC-1:0] mask,
  output logic               irq
);

  localparam int unsigned TOP_BIT = BASE_BIT + NUM_SRC - 1;

  logic [NUM_SRC-1:0] wfield;
  assign wfield = wdata[TOP_BIT:BASE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      cause <= (cause_we ? (cause & wfield) : cause) | set_in;
      if (mask_we) mask <= wfield;
    end
  end

  assign irq = |(cause & mask);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    assert_cause_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_in[s] |=> cause[s])
      else $error("expiry did not set cause");

    assert_cause_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_we && !wfield[s] && !set_in[s]) |=> !cause[s])
      else $error("cause bit written 0 not cleared");

    assert_cause_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_we && wfield[s] && cause[s]) |=> cause[s])
      else $error("cause bit written 1 was lost");
  end

  assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq)
    else $error("irq raised with every source masked");

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned CTL_W = CTL_BITS * NUM_TMR;

  dtt_hit_t           hit;
  logic               any_hit;
  logic               wr_en;
  logic               rd_en;
  logic [NUM_TMR-1:0] run;
  logic [NUM_TMR-1:0] rep;
  logic [NUM_TMR-1:0] expire;
  logic [CNT_W-1:0]   count  [NUM_TMR];
  logic [CNT_W-1:0]   reload [NUM_TMR];
  logic [NUM_TMR-1:0] cause;
  logic [NUM_TMR-1:0] mask;
  logic [CTL_W-1:0]   ctl_word;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  dtt_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .hit     (hit),
    .any_hit (any_hit)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    dtt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (wr_en && hit.ctrl),
      .ctl_run_in (bus_wdata[CTL_BITS*t]),
      .ctl_rep_in (bus_wdata[CTL_BITS*t+1]),
      .val_we     (wr_en && hit.val[t]),
      .val_in     (bus_wdata[CNT_W-1:0]),
      .rel_we     (wr_en && hit.rel[t]),
      .rel_in     (bus_wdata[CNT_W-1:0]),
      .run        (run[t]),
      .rep        (rep[t]),
      .count      (count[t]),
      .reload     (reload[t]),
      .expire     (expire[t])
    );
    assign ctl_word[CTL_BITS*t]   = run[t];
    assign ctl_word[CTL_BITS*t+1] = rep[t];
  end

  dtt_irq_bridge #(
    .NUM_SRC  (NUM_TMR),
    .DATA_W   (DATA_W),
    .BASE_BIT (CAUSE_LSB)
  ) u_bridge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cause_we (wr_en && hit.cause),
    .mask_we  (wr_en && hit.mask),
    .wdata    (bus_wdata),
    .set_in   (expire),
    .cause    (cause),
    .mask     (mask),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit.ctrl) bus_rdata[CTL_W-1:0] = ctl_word;
      for (int t = 0; t < NUM_TMR; t++) begin
        if (hit.val[t]) bus_rdata = DATA_W'(count[t]);
        if (hit.rel[t]) bus_rdata = DATA_W'(reload[t]);
      end
      if (hit.cause) bus_rdata[CAUSE_LSB +: NUM_TMR] = cause;
      if (hit.mask)  bus_rdata[CAUSE_LSB +: NUM_TMR] = mask;
    end
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !any_hit) |-> bus_rdata == '0)
    else $error("unmapped access returned data");

  assert_ctrl_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit.ctrl) |-> bus_rdata[DATA_W-1:CTL_W] == '0)
    else $error("control upper bits not zero");

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) != '0 || $past(wr_en && hit.mask)))
    else $error("irq rose without expiry or mask change");

endmodule

// File: tb/test_dual_tick_timer.sv
module test_dual_tick_timer;

  localparam int unsigned AW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dual_tick_timer i_dual_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic [3:0]  m_ctl;
  logic [31:0] m_rel [2];
  logic [31:0] m_val [2];
  logic [1:0]  m_cause;
  logic [1:0]  m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_rel[0] = '0; m_rel[1] = '0; m_val[0] = '0; m_val[1] = '0;
      m_cause = '0; m_mask = '0;
    end else begin
      logic [3:0]  n_ctl;
      logic [31:0] n_val [2];
      logic [1:0]  hitx;
      logic        w;
      w = bus_sel && bus_wr;
      n_ctl = m_ctl;
      hitx = '0;
      for (int t = 0; t < 2; t++) begin
        logic en, au;
        en = m_ctl[2*t]; au = m_ctl[2*t+1];
        n_val[t] = m_val[t];
        if (en && m_val[t] == 0) begin
          hitx[t] = 1'b1;
          if (!au) n_ctl[2*t] = 1'b0;
          n_val[t] = au ? m_rel[t] : 32'd0;
        end else if (en) n_val[t] = m_val[t] - 1;
      end
      if (w && bus_addr == 12'h000) n_ctl = bus_wdata[3:0];
      if (w && bus_addr == 12'h014) n_val[0] = bus_wdata;
      if (w && bus_addr == 12'h01C) n_val[1] = bus_wdata;
      if (w && bus_addr == 12'h010) m_rel[0] = bus_wdata;
      if (w && bus_addr == 12'h018) m_rel[1] = bus_wdata;
      if (w && bus_addr == 12'h110) m_cause = m_cause & bus_wdata[2:1];
      m_cause = m_cause | hitx;
      if (w && bus_addr == 12'h114) m_mask = bus_wdata[2:1];
      m_ctl = n_ctl; m_val[0] = n_val[0]; m_val[1] = n_val[1];
    end
  end

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    case (a)
      12'h000: return {28'd0, m_ctl};
      12'h010: return m_rel[0];
      12'h014: return m_val[0];
      12'h018: return m_rel[1];
      12'h01C: return m_val[1];
      12'h110: return {29'd0, m_cause, 1'b0};
      12'h114: return {29'd0, m_mask, 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [AW-1:0] a);
    case (a)
      12'h000: return "R5";
      12'h010, 12'h018: return "R2";
      12'h014, 12'h01C: return "R3";
      12'h110: return "R8";
      12'h114: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one bus cycle; reads compare against the model, irq always checked (R9)
  task automatic op(bit wr, logic [AW-1:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    if (!wr) check(tag, bus_rdata, mread(a));
    check("R9", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1;
      check("R9", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
    end
  endtask

  task automatic rd_expect(logic [AW-1:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    logic [AW-1:0] addrs [8];
    bit saw_wrap;
    seed = $urandom(32'h5EED);
    addrs[0] = 12'h000; addrs[1] = 12'h010; addrs[2] = 12'h014; addrs[3] = 12'h018;
    addrs[4] = 12'h01C; addrs[5] = 12'h110; addrs[6] = 12'h114; addrs[7] = 12'h004;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 7; i++) rd_expect(addrs[i], 32'd0, "R1");
    check("R1", {31'd0, irq}, 32'd0);

    // R2: reload read-back
    op(1, 12'h010, 32'h1234_5678, "R2");
    op(1, 12'h018, 32'h9ABC_DEF0, "R2");
    rd_expect(12'h010, 32'h1234_5678, "R2");
    rd_expect(12'h018, 32'h9ABC_DEF0, "R2");

    // R5/R7/R3: one-shot on timer 1, masked
    op(1, 12'h01C, 32'd3, "R6");
    op(1, 12'h000, 32'h4, "R5");
    for (int i = 0; i < 6; i++) op(0, 12'h01C, 0, "R3");
    rd_expect(12'h000, 32'd0, "R5");
    rd_expect(12'h01C, 32'd0, "R5");
    rd_expect(12'h110, 32'h4, "R7");
    check("R9", {31'd0, irq}, 32'd0);
    op(1, 12'h114, 32'h4, "R9");
    idle(1);
    check("R9", {31'd0, irq}, 32'd1);
    op(1, 12'h110, 32'hFFFF_FFFB, "R8");
    idle(1);
    rd_expect(12'h110, 32'd0, "R8");
    check("R9", {31'd0, irq}, 32'd0);

    // R4/R7/R8: periodic on timer 0, reload 2
    op(1, 12'h010, 32'd2, "R4");
    op(1, 12'h014, 32'd2, "R4");
    op(1, 12'h000, 32'h3, "R4");
    for (int i = 0; i < 8; i++) op(0, 12'h014, 0, "R4");
    rd_expect(12'h110, 32'h2, "R7");
    op(1, 12'h110, 32'h2, "R8");
    op(0, 12'h110, 0, "R8");
    // R6: value write overrides running decrement
    op(1, 12'h014, 32'h50, "R6");
    rd_expect(12'h014, 32'h50, "R6");

    // R11: wrap from zero to all ones
    op(1, 12'h000, 32'h0, "R11");
    op(1, 12'h010, 32'hFFFF_FFFF, "R11");
    op(1, 12'h014, 32'd1, "R11");
    op(1, 12'h000, 32'h3, "R11");
    saw_wrap = 1'b0;
    for (int i = 0; i < 5; i++) begin
      op(0, 12'h014, 0, "R11");
      if (bus_rdata == 32'hFFFF_FFFF) saw_wrap = 1'b1;
    end
    check("R11", {31'd0, saw_wrap}, 32'd1);

    // R10: unmapped writes and reads
    op(1, 12'h000, 32'h0, "R10");
    op(1, 12'h004, 32'hFFFF_FFFF, "R10");
    op(1, 12'h120, 32'hFFFF_FFFF, "R10");
    op(1, 12'h200, 32'hFFFF_FFFF, "R10");
    rd_expect(12'h004, 32'd0, "R10");
    rd_expect(12'h200, 32'd0, "R10");
    for (int i = 0; i < 7; i++) op(0, addrs[i], 0, tag_of(addrs[i]));
    op(1, 12'h000, 32'hFFFF_FFF0, "R10");
    rd_expect(12'h000, 32'd0, "R10");
    op(1, 12'h114, 32'hFFFF_FFF9, "R10");
    rd_expect(12'h114, 32'd0, "R10");

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      int unsigned p;
      p = $urandom % 10;
      a = (p == 9) ? AW'({$urandom % 1024, 2'b00}) : addrs[$urandom % 7];
      case ($urandom % 4)
        0: d = $urandom;
        1: d = 32'hFFFF_FFFF;
        default: d = $urandom % 12;
      endcase
      if (a == 12'h000) d = $urandom % 16;
      if ($urandom % 3 == 0) idle($urandom % 4);
      op($urandom % 2 == 0, a, d, tag_of(a));
    end
    for (int i = 0; i < 7; i++) op(0, addrs[i], 0, tag_of(addrs[i]));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule